// File: doc/BRIEF.md
# Sleep-Mode Power Control Register

This block decides when a device is asleep and which low-speed functions keep running while it sleeps. Software reaches one configuration register through a simple byte-addressed bus with separate write and read strobes. The register holds three sleep-time enables, one each for the low-speed oscillator, the clock-output buffer and the PWM, and a read-only shutdown flag.

The shutdown flag is sticky. Two kinds of write set it. One is a write to the configuration address whose address LSB is 1. The other is a write of any data to a dedicated sleep address. Only wake events clear it: a write to the normal-mode address, an alarm pulse, or an edge on the wake pin. The device is asleep while the flag is set or while the external sleep request is high.

Asleep, each effective enable takes its sleep-time bit and ignores the normal-mode enable. Awake, each effective enable follows its normal-mode input. The PWM may run in sleep only while the sleep-time oscillator enable is also set, since the low-speed clock is its only source.

Top module: `sleep_pwr_ctrl`

## Requirements
- R1: After reset, a read of the configuration register returns 8'hC0. This means sleep oscillator enable 1 (bit 7), sleep clock-buffer enable 1 (bit 6), sleep PWM enable 0 (bit 5), shutdown flag 0 (bit 4) and bits 3:0 at 0. After reset, sleep_o is 0.
- R2: A write to the configuration address (8'h20 or 8'h21) stores write-data bits 7:5 into the three sleep enables. If the address LSB is 1, the shutdown flag is also set on the same clock edge.
- R3: A configuration write with the address LSB at 0 leaves the shutdown flag unchanged. A read of any address also leaves it unchanged.
- R4: A write to the sleep address (8'h22 or 8'h23) sets the shutdown flag and leaves the sleep enables unchanged.
- R5: Each of the following clears the shutdown flag on the next clock edge: a write to the normal-mode address (8'h24 or 8'h25), a high alarm_i, or a change of level on wake_pin_i.
- R6: A wake event in the same cycle as a write that sets the flag leaves the flag cleared.
- R7: sleep_o is high when the shutdown flag is set or sleep_req_i is high. A set flag keeps sleep_o high while sleep_req_i is low.
- R8: While sleep_o is 1, osc_en_o equals the sleep oscillator bit and ckbuf_en_o equals the sleep clock-buffer bit. While sleep_o is 0, osc_en_o, ckbuf_en_o and pwm_en_o equal norm_osc_en_i, norm_ckbuf_en_i and norm_pwm_en_i. These outputs react in the same cycle as their inputs.
- R9: While sleep_o is 1, pwm_en_o is the AND of the sleep PWM bit and the sleep oscillator bit.
- R10: Write-data bit 4 and bits 3:0 are ignored. The shutdown flag reads back only its own state in bit 4, and bits 3:0 read as 0.
- R11: bus_rdata is 0 unless bus_rd is high and the address is the configuration address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address; bit 0 of a configuration write is the sleep bit |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high |
| sleep_req_i | input | 1 | External sleep request level |
| alarm_i | input | 1 | Alarm event, clears shutdown |
| wake_pin_i | input | 1 | Wake pin; any edge clears shutdown |
| norm_osc_en_i | input | 1 | Normal-mode oscillator enable |
| norm_ckbuf_en_i | input | 1 | Normal-mode clock-buffer enable |
| norm_pwm_en_i | input | 1 | Normal-mode PWM enable |
| sleep_o | output | 1 | Device is in sleep |
| osc_en_o | output | 1 | Effective oscillator enable |
| ckbuf_en_o | output | 1 | Effective clock-output buffer enable |
| pwm_en_o | output | 1 | Effective PWM enable |

## Verification
Register writes, shutdown set and shutdown clear all take effect at the first rising edge after the strobe or event. The bench therefore drives each stimulus on a falling edge and checks the result on the next falling edge. The effective enables, sleep_o and bus_rdata are combinational from state and inputs. They are checked 1 ns after their inputs change, with no clock edge in between. A wake-pin edge is seen at the rising edge after the pin toggles and clears the flag there, so the flag is checked on the following falling edge.

// File: rtl/sps_pkg.sv
package sps_pkg;
    // Bit positions in the configuration register (behavioural: software decodes them)
    localparam int BIT_SOSC  = 7;
    localparam int BIT_SCK   = 6;
    localparam int BIT_SPWM  = 5;
    localparam int BIT_SHDN  = 4;

    // Function indices for the enable mux
    localparam int FN_OSC   = 0;
    localparam int FN_CK    = 1;
    localparam int FN_PWM   = 2;
    localparam int N_FUNC   = 3;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_CFG   = 2'd1,
        SEL_SLEEP = 2'd2,
        SEL_NORM  = 2'd3
    } sps_sel_e;

    typedef struct packed {
        logic [N_FUNC-1:0] slp_en;
        logic              shdn;
    } sps_state_t;

    localparam logic [N_FUNC-1:0] SLP_EN_RST = 3'b011; // osc=1, ck=1, pwm=0
endpackage

// File: rtl/sps_decode.sv
module sps_decode
    import sps_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR   = 8'h20,
    parameter logic [ADDR_W-1:0] SLEEP_ADDR = 8'h22,
    parameter logic [ADDR_W-1:0] NORM_ADDR  = 8'h24
) (
    input  logic [ADDR_W-1:0] addr,
    output sps_sel_e          sel,
    output logic              lsb
);
    localparam int KEY_W = ADDR_W - 1;

    logic [KEY_W-1:0] key;
    assign key = addr[ADDR_W-1:1];
    assign lsb = addr[0];

    always_comb begin
        if (key == CFG_ADDR[ADDR_W-1:1])        sel = SEL_CFG;
        else if (key == SLEEP_ADDR[ADDR_W-1:1]) sel = SEL_SLEEP;
        else if (key == NORM_ADDR[ADDR_W-1:1])  sel = SEL_NORM;
        else                                    sel = SEL_NONE;
    end
endmodule

// File: rtl/sps_wake_detect.sv
module sps_wake_detect #(
    parameter bit BOTH_EDGES = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic edge_evt
);
    logic prev_d, prev_q;

    always_comb prev_d = pin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    generate
        if (BOTH_EDGES) begin : g_any
            assign edge_evt = pin ^ prev_q;
        end else begin : g_rise
            assign edge_evt = pin & ~prev_q;
        end
    endgenerate
endmodule

// File: rtl/sps_enable_mux.sv
module sps_enable_mux
    import sps_pkg::*;
(
    input  logic              in_sleep,
    input  logic [N_FUNC-1:0] slp_en,
    input  logic [N_FUNC-1:0] norm_en,
    output logic [N_FUNC-1:0] eff_en
);
    logic [N_FUNC-1:0] gate;

    always_comb begin
        gate         = '1;
        gate[FN_PWM] = slp_en[FN_OSC]; // PWM needs the low-speed clock in sleep
    end

    generate
        for (genvar i = 0; i < N_FUNC; i++) begin : g_fn
            assign eff_en[i] = in_sleep ? (slp_en[i] & gate[i]) : norm_en[i];
        end
    endgenerate
endmodule

// File: rtl/sleep_pwr_ctrl.sv
module sleep_pwr_ctrl
    import sps_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR   = 8'h20,
    parameter logic [ADDR_W-1:0] SLEEP_ADDR = 8'h22,
    parameter logic [ADDR_W-1:0] NORM_ADDR  = 8'h24,
    parameter bit                WAKE_BOTH_EDGES = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sleep_req_i,
    input  logic              alarm_i,
    input  logic              wake_pin_i,
    input  logic              norm_osc_en_i,
    input  logic              norm_ckbuf_en_i,
    input  logic              norm_pwm_en_i,
    output logic              sleep_o,
    output logic              osc_en_o,
    output logic              ckbuf_en_o,
    output logic              pwm_en_o
);
    sps_state_t state_d, state_q;
    sps_sel_e   sel;
    logic       addr_lsb;
    logic       wake_edge;
    logic       wake_evt;
    logic       set_req;
    logic       shdn_w;
    logic [N_FUNC-1:0] norm_en, eff_en;

    sps_decode #(
        .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR),
        .SLEEP_ADDR(SLEEP_ADDR), .NORM_ADDR(NORM_ADDR)
    ) i_decode (
        .addr(bus_addr), .sel(sel), .lsb(addr_lsb)
    );

    sps_wake_detect #(.BOTH_EDGES(WAKE_BOTH_EDGES)) i_wake (
        .clk(clk), .rst_n(rst_n), .pin(wake_pin_i), .edge_evt(wake_edge)
    );

    assign wake_evt = alarm_i | wake_edge | (bus_wr && sel == SEL_NORM);
    assign set_req  = bus_wr && ((sel == SEL_CFG && addr_lsb) || sel == SEL_SLEEP);

    always_comb begin
        state_d = state_q;
        if (bus_wr && sel == SEL_CFG) begin
            state_d.slp_en[FN_OSC] = bus_wdata[BIT_SOSC];
            state_d.slp_en[FN_CK]  = bus_wdata[BIT_SCK];
            state_d.slp_en[FN_PWM] = bus_wdata[BIT_SPWM];
        end
        if (wake_evt)     state_d.shdn = 1'b0;  // wake wins
        else if (set_req) state_d.shdn = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.slp_en <= SLP_EN_RST;
            state_q.shdn   <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign shdn_w  = state_q.shdn;
    assign sleep_o = state_q.shdn | sleep_req_i;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && sel == SEL_CFG) begin
            bus_rdata[BIT_SOSC] = state_q.slp_en[FN_OSC];
            bus_rdata[BIT_SCK]  = state_q.slp_en[FN_CK];
            bus_rdata[BIT_SPWM] = state_q.slp_en[FN_PWM];
            bus_rdata[BIT_SHDN] = state_q.shdn;
        end
    end

    always_comb begin
        norm_en         = '0;
        norm_en[FN_OSC] = norm_osc_en_i;
        norm_en[FN_CK]  = norm_ckbuf_en_i;
        norm_en[FN_PWM] = norm_pwm_en_i;
    end

    sps_enable_mux i_mux (
        .in_sleep(sleep_o), .slp_en(state_q.slp_en),
        .norm_en(norm_en), .eff_en(eff_en)
    );

    assign osc_en_o   = eff_en[FN_OSC];
    assign ckbuf_en_o = eff_en[FN_CK];
    assign pwm_en_o   = eff_en[FN_PWM];
endmodule

// File: rtl/sps_chk.sv
module sps_chk #(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR   = 8'h20,
    parameter logic [ADDR_W-1:0] SLEEP_ADDR = 8'h22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              alarm_i,
    input logic              wake_evt,
    input logic              shdn,
    input logic              sleep_o,
    input logic              osc_en_o,
    input logic              pwm_en_o
);
    logic is_cfg, is_sleep;
    assign is_cfg   = bus_addr[ADDR_W-1:1] == CFG_ADDR[ADDR_W-1:1];
    assign is_sleep = bus_addr[ADDR_W-1:1] == SLEEP_ADDR[ADDR_W-1:1];

    // R2
    set_on_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_cfg && bus_addr[0] && !wake_evt) |=> shdn);

    // R3
    lsb0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_cfg && !bus_addr[0] && !wake_evt) |=> $stable(shdn));

    // R3
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && !wake_evt) |=> $stable(shdn));

    // R4
    sleep_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_sleep && !wake_evt) |=> shdn);

    // R5
    alarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_i |=> !shdn);

    // R6
    wake_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_evt && bus_wr) |=> !shdn);

    // R7
    shdn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shdn |-> sleep_o);

    // R9
    pwm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && pwm_en_o) |-> osc_en_o);
endmodule

bind sleep_pwr_ctrl sps_chk #(
    .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .SLEEP_ADDR(SLEEP_ADDR)
) i_sps_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .alarm_i(alarm_i), .wake_evt(wake_evt),
    .shdn(shdn_w), .sleep_o(sleep_o), .osc_en_o(osc_en_o),
    .pwm_en_o(pwm_en_o)
);

// File: tb/test_sleep_pwr_ctrl.sv
`timescale 1ns/1ps
module test_sleep_pwr_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sleep_req_i = 0, alarm_i = 0, wake_pin_i = 0;
    logic       norm_osc_en_i = 0, norm_ckbuf_en_i = 0, norm_pwm_en_i = 0;
    logic       sleep_o, osc_en_o, ckbuf_en_o, pwm_en_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // expected model state
    logic [2:0] m_slp;   // {pwm, ck, osc}
    logic       m_shdn;

    always #2.5 clk = ~clk;

    sleep_pwr_ctrl i_sleep_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sleep_req_i(sleep_req_i), .alarm_i(alarm_i), .wake_pin_i(wake_pin_i),
        .norm_osc_en_i(norm_osc_en_i), .norm_ckbuf_en_i(norm_ckbuf_en_i),
        .norm_pwm_en_i(norm_pwm_en_i), .sleep_o(sleep_o), .osc_en_o(osc_en_o),
        .ckbuf_en_o(ckbuf_en_o), .pwm_en_o(pwm_en_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h00;
    endtask

    function automatic logic [7:0] exp_rd();
        return {m_slp[0], m_slp[1], m_slp[2], m_shdn, 4'b0000};
    endfunction

    task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check(req, bus_rdata, exp);
        bus_rd = 1'b0; bus_addr = 8'h00;
        #1;
    endtask

    // outputs {sleep, pwm, ck, osc}
    task automatic out_check(input string req);
        logic slp;
        logic [3:0] e;
        #1;
        slp = m_shdn | sleep_req_i;
        if (slp) e = {1'b1, m_slp[2] & m_slp[0], m_slp[1], m_slp[0]};
        else     e = {1'b0, norm_pwm_en_i, norm_ckbuf_en_i, norm_osc_en_i};
        check(req, {4'h0, sleep_o, pwm_en_o, ckbuf_en_o, osc_en_o}, {4'h0, e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_slp = 3'b011; m_shdn = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R11 idle read data
        rd_check("R1", 8'h20, 8'hC0);
        check("R1 sleep_o", {7'h0, sleep_o}, 8'h00);
        #1 check("R11 idle rdata", bus_rdata, 8'h00);
        rd_check("R11 unmapped read", 8'h30, 8'h00);
        rd_check("R11 sleep addr read", 8'h22, 8'h00);

        // R8/R9 sweep: every sleep-enable pattern, request, normal enables
        for (int v = 0; v < 8; v++) begin
            wr(8'h20, {v[0], v[1], v[2], 5'b10101});   // R10 low bits ignored
            m_slp = v[2:0];
            rd_check("R2/R10 cfg store", 8'h20, exp_rd());
            for (int r = 0; r < 2; r++) begin
                for (int n = 0; n < 8; n++) begin
                    sleep_req_i = r[0];
                    {norm_pwm_en_i, norm_ckbuf_en_i, norm_osc_en_i} = n[2:0];
                    out_check("R8/R9 sweep");
                end
            end
            sleep_req_i = 0;
        end

        // R3: lsb 0 write and reads keep shutdown clear
        wr(8'h20, 8'hE0); m_slp = 3'b111;
        rd_check("R3 lsb0 no set", 8'h20, exp_rd());

        // R2: lsb 1 sets shutdown and stores data
        wr(8'h21, 8'hA0); m_slp = 3'b101; m_shdn = 1;
        rd_check("R2 lsb1 set", 8'h20, exp_rd());

        // R7: shutdown holds sleep with request low; R8/R9 under shutdown
        sleep_req_i = 0;
        for (int n = 0; n < 8; n++) begin
            {norm_pwm_en_i, norm_ckbuf_en_i, norm_osc_en_i} = n[2:0];
            out_check("R7/R8 shdn sweep");
        end
        // R9: pwm bit set, osc bit clear -> pwm off in sleep
        wr(8'h20, 8'h20); m_slp = 3'b100;
        rd_check("R3 lsb0 keep set", 8'h20, exp_rd());
        out_check("R9 pwm gated");
        // R3 repeated reads
        rd_check("R3 read keep", 8'h21, exp_rd());
        @(negedge clk);
        rd_check("R3 read keep after edge", 8'h20, exp_rd());

        // R10: write data bit 4 ignored (cannot clear via data)
        wr(8'h20, 8'hC0); m_slp = 3'b011;
        rd_check("R10 shdn read-only", 8'h20, exp_rd());

        // R5: normal-mode address clears
        wr(8'h24, 8'h00); m_shdn = 0;
        rd_check("R5 norm clear", 8'h20, exp_rd());
        out_check("R7 awake");

        // R4: sleep address sets, enables unchanged
        wr(8'h23, 8'h00); m_shdn = 1;
        rd_check("R4 sleep addr", 8'h20, exp_rd());

        // R5: alarm clears
        @(negedge clk); alarm_i = 1;
        @(negedge clk); alarm_i = 0; m_shdn = 0;
        rd_check("R5 alarm clear", 8'h20, exp_rd());

        // R5: wake pin rising and falling edges
        wr(8'h22, 8'h00); m_shdn = 1;
        rd_check("R4 sleep addr again", 8'h20, exp_rd());
        @(negedge clk); wake_pin_i = 1;
        @(negedge clk); m_shdn = 0;
        rd_check("R5 wake rise", 8'h20, exp_rd());
        wr(8'h21, 8'hC0); m_shdn = 1;
        rd_check("R2 set again", 8'h20, exp_rd());
        @(negedge clk); wake_pin_i = 0;
        @(negedge clk); m_shdn = 0;
        rd_check("R5 wake fall", 8'h20, exp_rd());

        // R6: wake in the same cycle as a setting write
        @(negedge clk);
        bus_addr = 8'h21; bus_wdata = 8'h40; bus_wr = 1; alarm_i = 1;
        @(negedge clk);
        bus_wr = 0; alarm_i = 0; bus_addr = 8'h00; m_slp = 3'b010;
        rd_check("R6 alarm wins", 8'h20, exp_rd());
        wr(8'h22, 8'h00); m_shdn = 1;
        @(negedge clk);
        bus_addr = 8'h22; bus_wr = 1; wake_pin_i = 1;
        @(negedge clk);
        bus_wr = 0; bus_addr = 8'h00; m_shdn = 0;
        rd_check("R6 wake pin wins", 8'h20, exp_rd());

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule